// File: doc/BRIEF.md
# SPI Serial EEPROM Command Front End

This block is the slave side of a small serial EEPROM that holds 512 bytes. A fast system clock oversamples the SPI mode 0 pins (chip select, serial clock, serial input and a pause input). The block collects the first byte of each selected transfer as an instruction and decodes it. For reads it gathers the rest of the address and shifts array data out, most significant bit first. The output is a data bit plus an enable, and the enable stands for the high-impedance state of the pin.

Reads are served from an internal array model with a registered read port. Write-enable, write-disable, status-write and array-write instructions are passed to a separate write engine. The block sends that engine one strobe for the instruction and then one strobe for each complete byte that follows it. Status reads shift out a status byte supplied by the engine. A pause input can freeze a transfer partway through. When it is released, the transfer continues from the same bit.

Top module: `spi_eeprom_front`

## Requirements
- R1: After reset, and for as long as chip select is high, `so_en` is 0 and no engine strobe fires. Serial clock edges seen while chip select is high change nothing: a read that starts afterwards returns the correct data.
- R2: A read instruction has the form 0000A011, where bit 3 is address bit 8. It is followed by address bits 7..0. The addressed byte is then driven MSB first on `so_d`, starting after the serial clock falls following the last address bit. The output changes only after falling edges. The array is preset so that the byte at address a is ((a[7:0]*5+3) mod 256) XOR (a[8] ? 0xA5 : 0x00).
- R3: While chip select stays low, each later group of 8 clocks returns the byte at the next address. After address 0x1FF, the next byte comes from address 0x000.
- R4: A status read has the form 0000X101, where bit 3 is ignored. It shifts `stat_in` out MSB first, and it repeats that value for as long as clocking continues.
- R5: The following instructions each produce exactly one `eng_cmd_vld` pulse. `eng_cmd` carries the low three bits of the instruction and `eng_a8` carries bit 3. The codes are: write enable 0000X110, write disable 0000X100, status write 0000X001, array write 0000A010.
- R6: After a status-write or array-write instruction, each further complete byte produces one `eng_byte_vld` pulse with that byte on `eng_byte`, in the order received. An instruction strobe and a byte strobe never fire in the same cycle.
- R7: An instruction byte is invalid if its upper four bits are not 0000 or its low three bits are 000 or 111. After an invalid instruction, no input is taken, `so_en` stays 0 and no strobe fires until chip select rises and falls again.
- R8: A falling edge of `hold_n` while the serial clock is low pauses the transfer. During the pause `so_en` is 0 and serial clock edges and `si` are ignored. A rising edge of `hold_n` while the serial clock is low resumes the transfer at the same bit.
- R9: If chip select rises partway through any sequence, the block returns to idle. The next selected transfer starts with a fresh instruction byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| so_d | output | 1 | Serial data out value |
| so_en | output | 1 | Serial output drive enable (0 = high impedance) |
| stat_in | input | 8 | Status byte from the write engine |
| eng_cmd_vld | output | 1 | One-cycle strobe for an instruction sent to the write engine |
| eng_cmd | output | 3 | Low three instruction bits |
| eng_a8 | output | 1 | Bit 3 of the instruction |
| eng_byte_vld | output | 1 | One-cycle strobe for a received byte |
| eng_byte | output | 8 | Received byte |

## Verification
The hardest case to reach is a pause that lands partway through a byte. The transfer must then resume on exactly the right bit after the serial clock has kept toggling with changing input data. The stimulus drops `hold_n` during the low phase of a chosen bit, once during the address byte and once during the data byte. It clocks several bits of noise, releases the pause, and checks that the address and data still match the array pattern. A read that runs past 0x1FF and a read that crosses from address 0x0FF to 0x100 check both address bit 8 and the wrap.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_RDOUT,
    PH_STOUT,
    PH_WIN,
    PH_LOCK
  } ph_t;

  localparam logic [2:0] OPC_WREN  = 3'b110;
  localparam logic [2:0] OPC_WRDI  = 3'b100;
  localparam logic [2:0] OPC_RDSR  = 3'b101;
  localparam logic [2:0] OPC_WRSR  = 3'b001;
  localparam logic [2:0] OPC_READ  = 3'b011;
  localparam logic [2:0] OPC_WRITE = 3'b010;

  // Preset contents of the array model.
  function automatic logic [7:0] preset_byte(input logic [8:0] a);
    logic [7:0] b;
    b = a[7:0] * 8'd5 + 8'd3;
    return b ^ (a[8] ? 8'hA5 : 8'h00);
  endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int             N      = 4,
  parameter int             STAGES = 2,
  parameter logic [N-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    // pipe[STAGES-1] is the synchronized value, pipe[STAGES] its previous one
    logic [STAGES:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= {(STAGES+1){INIT[g]}};
      else     pipe <= {pipe[STAGES-1:0], d[g]};
    end
    assign q[g]    = pipe[STAGES-1];
    assign rise[g] = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall[g] = ~pipe[STAGES-1] & pipe[STAGES];
  end

endmodule

// File: rtl/spi_ee_decode.sv
module spi_ee_decode
  import spi_ee_pkg::*;
(
  input  logic [7:0] op_byte,
  output logic       op_ok,
  output logic       op_read,
  output logic       op_stat,
  output logic       op_eng,
  output logic       op_data
);

  logic [2:0] low;
  assign low = op_byte[2:0];

  always_comb begin
    op_ok   = (op_byte[7:4] == 4'h0) && (low != 3'b000) && (low != 3'b111);
    op_read = op_ok && (low == OPC_READ);
    op_stat = op_ok && (low == OPC_RDSR);
    op_eng  = op_ok && (low == OPC_WREN || low == OPC_WRDI ||
                        low == OPC_WRSR || low == OPC_WRITE);
    op_data = op_ok && (low == OPC_WRSR || low == OPC_WRITE);
  end

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array
  import spi_ee_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(preset_byte(9'(i)));
  end

  always_ff @(posedge clk) rdata <= mem[raddr];

endmodule

// File: rtl/spi_eeprom_front.sv
module spi_eeprom_front
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       hold_n,
  output logic       so_d,
  output logic       so_en,
  input  logic [7:0] stat_in,
  output logic       eng_cmd_vld,
  output logic [2:0] eng_cmd,
  output logic       eng_a8,
  output logic       eng_byte_vld,
  output logic [7:0] eng_byte
);

  localparam int         FULL_W = 9;
  localparam logic [8:0] AMASK  = 9'((32'd1 << ADDR_W) - 1);

  // pin order: 0 sck, 1 cs_n, 2 hold_n, 3 si
  logic [3:0] pin_q, pin_rise, pin_fall;

  spi_ee_sync #(.N(4), .STAGES(SYNC_STAGES), .INIT(4'b0110)) u_sync (
    .clk (clk), .rst (rst),
    .d   ({si, hold_n, cs_n, sck}),
    .q   (pin_q), .rise (pin_rise), .fall (pin_fall)
  );

  logic sck_s, cs_s, si_s, sck_rise, sck_fall;
  assign sck_s    = pin_q[0];
  assign cs_s     = pin_q[1];
  assign si_s     = pin_q[3];
  assign sck_rise = pin_rise[0];
  assign sck_fall = pin_fall[0];

  // pause state: pause pin edges count only while the serial clock is low
  logic held;
  always_ff @(posedge clk) begin
    if (rst || cs_s)  held <= 1'b0;
    else if (!sck_s) begin
      if (pin_fall[2])      held <= 1'b1;
      else if (pin_rise[2]) held <= 1'b0;
    end
  end

  logic act_rise, act_fall;
  assign act_rise = sck_rise && !cs_s && !held;
  assign act_fall = sck_fall && !cs_s && !held;

  ph_t         ph;
  logic [2:0]  bitcnt;
  logic [7:0]  shin, shout;
  logic [FULL_W-1:0] addr_q;
  logic        load_pend, out_live;
  logic [7:0]  nb;
  logic [7:0]  rdata;

  assign nb = {shin[6:0], si_s};

  logic op_ok, op_read, op_stat, op_eng, op_data;

  spi_ee_decode u_dec (
    .op_byte (nb),
    .op_ok   (op_ok),
    .op_read (op_read),
    .op_stat (op_stat),
    .op_eng  (op_eng),
    .op_data (op_data)
  );

  spi_ee_array #(.AW(ADDR_W), .DW(8)) u_arr (
    .clk   (clk),
    .raddr (addr_q[ADDR_W-1:0]),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    eng_cmd_vld  <= 1'b0;
    eng_byte_vld <= 1'b0;
    if (rst) begin
      eng_cmd  <= '0;
      eng_a8   <= 1'b0;
      eng_byte <= '0;
      addr_q   <= '0;
      shin     <= '0;
      shout    <= '0;
    end
    if (rst || cs_s) begin
      ph        <= PH_OPC;
      bitcnt    <= '0;
      load_pend <= 1'b0;
      out_live  <= 1'b0;
    end else if (act_rise && ph != PH_LOCK) begin
      shin   <= nb;
      bitcnt <= bitcnt + 3'd1;
      if (bitcnt == 3'd7) begin
        unique case (ph)
          PH_OPC: begin
            if (!op_ok) ph <= PH_LOCK;
            else if (op_read) begin
              ph     <= PH_ADDR;
              addr_q <= {nb[3], 8'h00} & AMASK;
            end else if (op_stat) begin
              ph        <= PH_STOUT;
              load_pend <= 1'b1;
            end else if (op_eng) begin
              eng_cmd_vld <= 1'b1;
              eng_cmd     <= nb[2:0];
              eng_a8      <= nb[3];
              ph          <= op_data ? PH_WIN : PH_LOCK;
            end
          end
          PH_ADDR: begin
            addr_q    <= {addr_q[8], nb} & AMASK;
            ph        <= PH_RDOUT;
            load_pend <= 1'b1;
          end
          PH_RDOUT: begin
            addr_q    <= (addr_q + 9'd1) & AMASK;
            load_pend <= 1'b1;
          end
          PH_STOUT: load_pend <= 1'b1;
          PH_WIN: begin
            eng_byte_vld <= 1'b1;
            eng_byte     <= nb;
          end
          default: ;
        endcase
      end
    end else if (act_fall && (ph == PH_RDOUT || ph == PH_STOUT)) begin
      if (load_pend) begin
        shout     <= (ph == PH_STOUT) ? stat_in : rdata;
        load_pend <= 1'b0;
        out_live  <= 1'b1;
      end else begin
        shout <= {shout[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) so_en <= 1'b0;
    else     so_en <= !cs_s && !held && out_live &&
                      (ph == PH_RDOUT || ph == PH_STOUT);
  end

  assign so_d = shout[7];

endmodule

// File: rtl/spi_ee_chk.sv
module spi_ee_chk
  import spi_ee_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cs_s,
  input logic       held,
  input logic       sck_fall,
  input ph_t        ph,
  input logic       so_en,
  input logic       so_d,
  input logic       eng_cmd_vld,
  input logic [2:0] eng_cmd,
  input logic       eng_byte_vld
);

  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !so_en); // R1

  AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    so_en && $past(so_en) && !$past(sck_fall) |-> $stable(so_d)); // R2

  AST_ENG_CODE: assert property (@(posedge clk) disable iff (rst)
    eng_cmd_vld |-> (eng_cmd == OPC_WREN || eng_cmd == OPC_WRDI ||
                     eng_cmd == OPC_WRSR || eng_cmd == OPC_WRITE)); // R5

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(eng_cmd_vld && eng_byte_vld)); // R6

  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (rst)
    ph == PH_LOCK |-> !so_en && !eng_byte_vld); // R7

  AST_HOLD_HIZ: assert property (@(posedge clk) disable iff (rst)
    held |=> !so_en); // R8

endmodule

bind spi_eeprom_front spi_ee_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cs_s         (cs_s),
  .held         (held),
  .sck_fall     (sck_fall),
  .ph           (ph),
  .so_en        (so_en),
  .so_d         (so_d),
  .eng_cmd_vld  (eng_cmd_vld),
  .eng_cmd      (eng_cmd),
  .eng_byte_vld (eng_byte_vld)
);

// File: tb/spi_eeprom_front_bench.sv
module spi_eeprom_front_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic [7:0] stat_in = 8'h00;
  logic so_d, so_en, eng_cmd_vld, eng_a8, eng_byte_vld;
  logic [2:0] eng_cmd;
  logic [7:0] eng_byte;

  always #2 clk = ~clk;

  spi_eeprom_front u_spi_eeprom_front (
    .clk (clk), .rst (rst), .cs_n (cs_n), .sck (sck), .si (si),
    .hold_n (hold_n), .so_d (so_d), .so_en (so_en), .stat_in (stat_in),
    .eng_cmd_vld (eng_cmd_vld), .eng_cmd (eng_cmd), .eng_a8 (eng_a8),
    .eng_byte_vld (eng_byte_vld), .eng_byte (eng_byte)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int en_cnt = 0, cmd_cnt = 0, byte_cnt = 0;
  logic [2:0] last_cmd;
  logic last_a8;
  logic [7:0] got [16];

  always @(negedge clk) begin
    if (!rst) begin
      if (so_en) en_cnt++;
      if (eng_cmd_vld) begin cmd_cnt++; last_cmd = eng_cmd; last_a8 = eng_a8; end
      if (eng_byte_vld) begin got[byte_cnt % 16] = eng_byte; byte_cnt++; end
    end
  end

  function automatic logic [7:0] pat(input int a);
    logic [8:0] aa;
    logic [7:0] b;
    aa = 9'(a % 512);
    b = aa[7:0] * 8'd5 + 8'd3;
    return b ^ (aa[8] ? 8'hA5 : 8'h00);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (10) @(negedge clk);
  endtask

  task automatic clr();
    en_cnt = 0; cmd_cnt = 0; byte_cnt = 0;
  endtask

  // shift one byte (nbits MSB-first bits); pause before bit hold_at if >= 0
  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      input int hold_at = -1, input int nbits = 8);
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (i == hold_at) begin
        hold_n = 1'b0;
        half();
        chk("R8 paused output", so_en, 1'b0);
        for (int k = 0; k < 3; k++) begin
          si = ~si; sck = 1'b1; half(); sck = 1'b0; half();
        end
        hold_n = 1'b1;
        half();
      end
      si = tx[i];
      half();
      rx[i] = so_d;
      sck = 1'b1;
      half();
      sck = 1'b0;
    end
  endtask

  task automatic sel();  cs_n = 1'b0; half(); endtask
  task automatic desel(); half(); cs_n = 1'b1; half(); half(); endtask

  // address[12:4], byte count[3:0]
  localparam logic [12:0] VEC [5] = '{
    {9'h000, 4'd1}, {9'h0FE, 4'd3}, {9'h1FE, 4'd4}, {9'h123, 4'd2}, {9'h080, 4'd1}
  };

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] rx;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    half();
    chk("R1 reset so_en", so_en, 1'b0);
    chk("R1 reset cmd strobe", eng_cmd_vld, 1'b0);

    // table-driven reads
    for (int v = 0; v < 5; v++) begin
      logic [8:0] a;
      a = VEC[v][12:4];
      sel();
      xfer({4'h0, a[8], 3'b011}, rx);
      xfer(a[7:0], rx);
      for (int k = 0; k < int'(VEC[v][3:0]); k++) begin
        xfer(8'h00, rx);
        chk(k == 0 ? "R2 read byte" : "R3 sequential byte", rx, pat(int'(a) + k));
      end
      desel();
    end

    // clock toggles with chip select high are ignored
    clr();
    for (int k = 0; k < 5; k++) begin si = ~si; sck = 1'b1; half(); sck = 1'b0; half(); end
    chk("R1 no output deselected", en_cnt, 0);
    chk("R1 no strobe deselected", cmd_cnt, 0);
    sel(); xfer(8'h03, rx); xfer(8'h21, rx); xfer(8'h00, rx); desel();
    chk("R1 read after idle clocks", rx, pat(9'h021));

    // status read, don't-care bit set
    stat_in = 8'h8C;
    sel(); xfer(8'h0D, rx); xfer(8'h00, rx);
    chk("R4 status first", rx, 8'h8C);
    xfer(8'h00, rx);
    chk("R4 status repeat", rx, 8'h8C);
    desel();

    // engine instructions
    clr();
    sel(); xfer(8'h0E, rx); xfer(8'h55, rx); desel();
    chk("R5 write enable count", cmd_cnt, 1);
    chk("R5 write enable code", last_cmd, 3'b110);
    chk("R5 no bytes after write enable", byte_cnt, 0);
    clr();
    sel(); xfer(8'h04, rx); desel();
    chk("R5 write disable code", last_cmd, 3'b100);
    clr();
    sel(); xfer(8'h0A, rx); xfer(8'h34, rx); xfer(8'h77, rx); desel();
    chk("R5 write code", last_cmd, 3'b010);
    chk("R5 write a8", last_a8, 1'b1);
    chk("R6 byte count", byte_cnt, 2);
    chk("R6 address byte", got[0], 8'h34);
    chk("R6 data byte", got[1], 8'h77);
    clr();
    sel(); xfer(8'h01, rx); xfer(8'h0C, rx); desel();
    chk("R5 status write code", last_cmd, 3'b001);
    chk("R6 status write byte", got[0], 8'h0C);

    // invalid instructions lock the interface
    clr();
    sel(); xfer(8'hFF, rx); xfer(8'h03, rx); xfer(8'h10, rx); xfer(8'h00, rx); desel();
    chk("R7 no output after 0xFF", en_cnt, 0);
    chk("R7 no strobe after 0xFF", cmd_cnt + byte_cnt, 0);
    clr();
    sel(); xfer(8'h12, rx); xfer(8'h0A, rx); xfer(8'h44, rx); desel();
    chk("R7 no strobe after 0x12", cmd_cnt + byte_cnt, 0);
    clr();
    sel(); xfer(8'h00, rx); xfer(8'h06, rx); desel();
    chk("R7 no strobe after 0x00", cmd_cnt, 0);
    sel(); xfer(8'h03, rx); xfer(8'h55, rx); xfer(8'h00, rx); desel();
    chk("R7 recovered after new select", rx, pat(9'h055));

    // pause in address and in data
    sel();
    xfer(8'h0B, rx);
    xfer(8'h3C, rx, 4);
    xfer(8'h00, rx, 4);
    chk("R8 data after paused address", rx, pat(9'h13C));
    xfer(8'h00, rx, 2);
    chk("R8 next byte after pause", rx, pat(9'h13D));
    desel();

    // abort mid-address
    sel(); xfer(8'h03, rx); xfer(8'hF0, rx, -1, 4); desel();
    sel(); xfer(8'h03, rx); xfer(8'h10, rx); xfer(8'h00, rx); desel();
    chk("R9 read after abort", rx, pat(9'h010));

    summary();
  end

endmodule